// File: doc/BRIEF.md
# Thermal Foldback Phase Tracker

This block follows the thermal state of a system from a thermistor voltage that has already been digitised. Each sample arrives as an unsigned ADC code with a valid strobe. The voltage must rise as temperature rises. From these samples the block keeps a foldback phase index. Phase 0 means normal operation, and each higher phase is hotter than the one below it. The power-management logic downstream reads that index to reduce the power it allows. A one-cycle change pulse marks every update of the index.

Every phase has an entry threshold and a lower exit threshold, so each boundary has its own hysteresis band. The phase moves by at most one step per sample. A large jump in voltage therefore settles over several consecutive samples. The thresholds and the number of enabled phases (0 to `PHASE_MAX`, default three) are written through a plain write-only register port. The current settings are checked all the time. When they are inconsistent, an error flag is raised and the tracker is held in phase 0.

Top module: `thermal_phase_tracker`

## Requirements
- R1: After reset, `phase_o` is 0, `phase_chg_o` is 0 and `cfg_err_o` is 0. The reset configuration is three phases with entry/exit codes 574/392, 938/686 and 1386/1078 for phases 1, 2 and 3 (1 mV per code).
- R2: A valid sample whose code is greater than or equal to the entry threshold of phase p+1 moves the tracker from phase p to phase p+1. This applies only when p is below the enabled count. The new index appears on the clock edge that takes the sample.
- R3: In phase p > 0, a valid sample whose code is strictly below the exit threshold of phase p moves the tracker to phase p-1.
- R4: A valid sample at or above the exit threshold of the current phase, and below the entry threshold of the next phase, leaves the phase unchanged.
- R5: The phase changes by at most one step per clock. Without a valid sample it does not change at all, except for the forced return of R9.
- R6: `phase_chg_o` is high for exactly one cycle after each clock edge that changes `phase_o`, and low otherwise.
- R7: In the highest enabled phase, no sample moves the tracker higher. `phase_o` never exceeds `PHASE_MAX`.
- R8: `cfg_err_o` is high when the enabled count exceeds `PHASE_MAX`. It is also high when, for the enabled phases, the sequence exit1, entry1, exit2, entry2, ... is not strictly increasing. This covers both an exit threshold that is not below its own entry threshold and an overlap between neighbouring phases.
- R9: While `cfg_err_o` is high, the tracker returns to phase 0 on the next clock edge, with or without a sample, and stays there.
- R10: If the enabled count is lowered below the current phase, the phase stays put until samples arrive. Each valid sample then lowers it by one, whatever its code, until it is within the enabled count.
- R11: Register map on `cfg_addr_i`: address 0 holds the enabled count in the low `$clog2(PHASE_MAX+1)` bits of `cfg_wdata_i`. Address 2k+1 holds the entry threshold and address 2k+2 the exit threshold of phase k+1. Writes to addresses above 2*`PHASE_MAX` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe for a new thermistor sample |
| sample_i | input | CODE_W | Unsigned thermistor voltage code |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(2*PHASE_MAX+1) | Configuration register address |
| cfg_wdata_i | input | CODE_W | Configuration write data |
| phase_o | output | $clog2(PHASE_MAX+1) | Current foldback phase, 0 = normal |
| phase_chg_o | output | 1 | One-cycle pulse after a phase change |
| cfg_err_o | output | 1 | Configuration inconsistent |

## Verification
The assertions check the following on every cycle: the single-step limit, the absence of motion without a sample, the agreement between the change pulse and the index, the forced return to phase 0 under a configuration error, and the upper bound on the index. Some behaviours need chosen codes and configurations, so only the bench scenarios can show them. These are the exact threshold edges (a code equal to an entry threshold enters, a code equal to an exit threshold holds), the hysteresis band, the stepwise settling after a large jump, the step-down after the enabled count is lowered, each error condition, the ignored out-of-range write and a six-phase custom setup.

// File: rtl/thermfb_pkg.sv
package thermfb_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_CLEAR = 2'd3
  } step_e;

  // Reset thresholds in 1 mV codes; phases past the third start at zero
  function automatic int dflt_entry(input int k);
    case (k)
      0:       return 574;
      1:       return 938;
      2:       return 1386;
      default: return 0;
    endcase
  endfunction

  function automatic int dflt_exit(input int k);
    case (k)
      0:       return 392;
      1:       return 686;
      2:       return 1078;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/thermfb_cfg_regs.sv
module thermfb_cfg_regs #(
  parameter int PHASE_MAX  = 6,
  parameter int CODE_W     = 12,
  parameter int DEF_PHASES = 3,
  localparam int PW = $clog2(PHASE_MAX + 1),
  localparam int AW = $clog2(2 * PHASE_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [PW-1:0]     num_o,
  output logic [CODE_W-1:0] entry_o [PHASE_MAX],
  output logic [CODE_W-1:0] exit_o  [PHASE_MAX]
);
  import thermfb_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= PW'(DEF_PHASES);
    end else if (we_i && addr_i == '0) begin
      num_o <= wdata_i[PW-1:0];
    end
  end

  for (genvar k = 0; k < PHASE_MAX; k++) begin : g_thr
    localparam logic [AW-1:0] ENTRY_ADDR = AW'(2 * k + 1);
    localparam logic [AW-1:0] EXIT_ADDR  = AW'(2 * k + 2);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_o[k] <= CODE_W'(dflt_entry(k));
        exit_o[k]  <= CODE_W'(dflt_exit(k));
      end else if (we_i) begin
        if (addr_i == ENTRY_ADDR) entry_o[k] <= wdata_i;
        if (addr_i == EXIT_ADDR)  exit_o[k]  <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/thermfb_cfg_check.sv
module thermfb_cfg_check #(
  parameter int PHASE_MAX = 6,
  parameter int CODE_W    = 12,
  localparam int PW   = $clog2(PHASE_MAX + 1),
  localparam int NSEQ = 2 * PHASE_MAX
) (
  input  logic [PW-1:0]     num_i,
  input  logic [CODE_W-1:0] entry_i [PHASE_MAX],
  input  logic [CODE_W-1:0] exit_i  [PHASE_MAX],
  output logic              err_o
);

  // Interleaved ladder exit1, entry1, exit2, entry2, ...
  logic [CODE_W-1:0] ladder [NSEQ];
  logic [NSEQ-1:0]   bad;
  logic              cnt_bad;

  for (genvar k = 0; k < PHASE_MAX; k++) begin : g_ladder
    assign ladder[2*k]   = exit_i[k];
    assign ladder[2*k+1] = entry_i[k];
  end

  assign bad[0] = 1'b0;

  for (genvar j = 1; j < NSEQ; j++) begin : g_order
    localparam logic [PW:0] JV = (PW + 1)'(j);
    // Rung j is live when it belongs to an enabled phase
    assign bad[j] = (JV < {num_i, 1'b0}) && (ladder[j] <= ladder[j-1]);
  end

  assign cnt_bad = num_i > PW'(PHASE_MAX);
  assign err_o   = cnt_bad || (|bad);

endmodule

// File: rtl/thermfb_step_sel.sv
module thermfb_step_sel #(
  parameter int PHASE_MAX = 6,
  parameter int CODE_W    = 12,
  localparam int PW = $clog2(PHASE_MAX + 1)
) (
  input  logic                     valid_i,
  input  logic [CODE_W-1:0]        sample_i,
  input  logic [PW-1:0]            phase_i,
  input  logic [PW-1:0]            num_i,
  input  logic                     err_i,
  input  logic [CODE_W-1:0]        entry_i [PHASE_MAX],
  input  logic [CODE_W-1:0]        exit_i  [PHASE_MAX],
  output thermfb_pkg::step_e       step_o
);
  import thermfb_pkg::*;

  logic [PHASE_MAX-1:0] at_entry;
  logic [PHASE_MAX-1:0] under_exit;
  logic                 up_hit;
  logic                 dn_hit;

  for (genvar k = 0; k < PHASE_MAX; k++) begin : g_cmp
    assign at_entry[k]   = sample_i >= entry_i[k];
    assign under_exit[k] = sample_i <  exit_i[k];
  end

  // Pick the comparators around the current phase
  always_comb begin
    up_hit = 1'b0;
    dn_hit = 1'b0;
    for (int k = 0; k < PHASE_MAX; k++) begin
      if (phase_i == PW'(k))     up_hit = at_entry[k];
      if (phase_i == PW'(k + 1)) dn_hit = under_exit[k];
    end
  end

  always_comb begin
    if (err_i)                                 step_o = STEP_CLEAR;
    else if (!valid_i)                         step_o = STEP_HOLD;
    else if (phase_i > num_i)                  step_o = STEP_DOWN;
    else if (phase_i < num_i && up_hit)        step_o = STEP_UP;
    else if (phase_i != '0 && dn_hit)          step_o = STEP_DOWN;
    else                                       step_o = STEP_HOLD;
  end

endmodule

// File: rtl/thermfb_phase_reg.sv
module thermfb_phase_reg #(
  parameter int PHASE_MAX = 6,
  localparam int PW = $clog2(PHASE_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  thermfb_pkg::step_e step_i,
  output logic [PW-1:0]      phase_o,
  output logic               chg_o
);
  import thermfb_pkg::*;

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] phase_nxt;

  always_comb begin
    unique case (step_i)
      STEP_UP:    phase_nxt = phase_o + ONE;
      STEP_DOWN:  phase_nxt = phase_o - ONE;
      STEP_CLEAR: phase_nxt = '0;
      default:    phase_nxt = phase_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      chg_o   <= 1'b0;
    end else begin
      phase_o <= phase_nxt;
      chg_o   <= phase_nxt != phase_o;
    end
  end

endmodule

// File: rtl/thermal_phase_tracker.sv
module thermal_phase_tracker #(
  parameter int PHASE_MAX  = 6,
  parameter int CODE_W     = 12,
  parameter int DEF_PHASES = 3,
  localparam int PW = $clog2(PHASE_MAX + 1),
  localparam int AW = $clog2(2 * PHASE_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [CODE_W-1:0] cfg_wdata_i,
  output logic [PW-1:0]     phase_o,
  output logic              phase_chg_o,
  output logic              cfg_err_o
);
  import thermfb_pkg::*;

  logic [PW-1:0]     num_q;
  logic [CODE_W-1:0] entry_q [PHASE_MAX];
  logic [CODE_W-1:0] exit_q  [PHASE_MAX];
  step_e             step;

  thermfb_cfg_regs #(
    .PHASE_MAX (PHASE_MAX),
    .CODE_W    (CODE_W),
    .DEF_PHASES(DEF_PHASES)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .num_o  (num_q),
    .entry_o(entry_q),
    .exit_o (exit_q)
  );

  thermfb_cfg_check #(
    .PHASE_MAX(PHASE_MAX),
    .CODE_W   (CODE_W)
  ) u_check (
    .num_i  (num_q),
    .entry_i(entry_q),
    .exit_i (exit_q),
    .err_o  (cfg_err_o)
  );

  thermfb_step_sel #(
    .PHASE_MAX(PHASE_MAX),
    .CODE_W   (CODE_W)
  ) u_sel (
    .valid_i (sample_valid_i),
    .sample_i(sample_i),
    .phase_i (phase_o),
    .num_i   (num_q),
    .err_i   (cfg_err_o),
    .entry_i (entry_q),
    .exit_i  (exit_q),
    .step_o  (step)
  );

  thermfb_phase_reg #(
    .PHASE_MAX(PHASE_MAX)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .phase_o(phase_o),
    .chg_o  (phase_chg_o)
  );

endmodule

// File: rtl/thermfb_checker.sv
module thermfb_checker #(
  parameter int PHASE_MAX = 6,
  localparam int PW = $clog2(PHASE_MAX + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic [PW-1:0] phase_o,
  input logic          phase_chg_o,
  input logic          cfg_err_o
);

  localparam logic [PW-1:0] ONE = PW'(1);

  a_r5_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && !cfg_err_o) |=> $stable(phase_o));

  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_err_o |=> (phase_o == $past(phase_o) ||
                    phase_o == $past(phase_o) + ONE ||
                    phase_o + ONE == $past(phase_o)));

  a_r6_pulse_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> phase_chg_o);

  a_r6_no_pulse_when_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == $past(phase_o)) |-> !phase_chg_o);

  a_r9_error_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> phase_o == '0);

  a_r7_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= PW'(PHASE_MAX));

endmodule

bind thermal_phase_tracker thermfb_checker #(
  .PHASE_MAX(PHASE_MAX)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .phase_o       (phase_o),
  .phase_chg_o   (phase_chg_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/tb_thermal_phase_tracker.sv
`timescale 1ns/1ps
module tb_thermal_phase_tracker;
  localparam int PHASE_MAX = 6;
  localparam int CODE_W    = 12;
  localparam int PW = $clog2(PHASE_MAX + 1);
  localparam int AW = $clog2(2 * PHASE_MAX + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sample_valid_i = 1'b0;
  logic [CODE_W-1:0] sample_i = '0;
  logic              cfg_we_i = 1'b0;
  logic [AW-1:0]     cfg_addr_i = '0;
  logic [CODE_W-1:0] cfg_wdata_i = '0;
  logic [PW-1:0]     phase_o;
  logic              phase_chg_o;
  logic              cfg_err_o;

  thermal_phase_tracker #(.PHASE_MAX(PHASE_MAX), .CODE_W(CODE_W)) dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    int    phase;
    bit    chg;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic took = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one sample, expected result queued for the monitor
  task automatic smp(input int code, input int ph, input bit chg, input string tag);
    exp_t e;
    @(negedge clk_i);
    e.phase = ph; e.chg = chg; e.tag = tag;
    exp_q.push_back(e);
    sample_valid_i = 1'b1;
    sample_i = CODE_W'(code);
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_addr_i = AW'(addr);
    cfg_wdata_i = CODE_W'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  always @(posedge clk_i) took <= sample_valid_i;

  // Monitor: compare after each edge that took a sample
  always @(negedge clk_i) begin
    if (took) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "monitor queue empty", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(phase_o) == e.phase, {e.tag, " phase"}, int'(phase_o), e.phase);
        check(phase_chg_o == e.chg, {e.tag, " pulse"}, int'(phase_chg_o), int'(e.chg));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(phase_o == '0, "R1 reset phase", int'(phase_o), 0);
    check(!phase_chg_o, "R1 reset pulse", int'(phase_chg_o), 0);
    check(!cfg_err_o, "R1 reset error", int'(cfg_err_o), 0);

    smp(573, 0, 0, "R4 below entry1");
    smp(574, 1, 1, "R2 equal entry1 (R1 default)");
    smp(600, 1, 0, "R4 inside band");
    smp(392, 1, 0, "R3 equal exit1 holds");
    smp(391, 0, 1, "R3 below exit1");
    smp(4000, 1, 1, "R5 jump step1");
    smp(4000, 2, 1, "R5 jump step2");
    smp(4000, 3, 1, "R5 jump step3");
    smp(4000, 3, 0, "R7 top phase cap");
    repeat (3) @(negedge clk_i);
    check(phase_o == PW'(3), "R5 idle holds", int'(phase_o), 3);
    check(!phase_chg_o, "R6 idle no pulse", int'(phase_chg_o), 0);
    smp(0, 2, 1, "R5 fall step1");
    smp(0, 1, 1, "R5 fall step2");
    smp(0, 0, 1, "R5 fall step3");
    smp(4000, 1, 1, "R2 rise again 1");
    smp(4000, 2, 1, "R2 rise again 2");
    smp(4000, 3, 1, "R2 rise again 3");

    wr(0, 2);
    check(phase_o == PW'(3), "R10 no move on count write", int'(phase_o), 3);
    smp(4000, 2, 1, "R10 step down to count");
    smp(4000, 2, 0, "R10 within count");

    wr(4, 1000);
    check(cfg_err_o, "R8 exit above entry", int'(cfg_err_o), 1);
    check(phase_o == PW'(2), "R9 phase before clear", int'(phase_o), 2);
    @(negedge clk_i);
    check(phase_o == '0, "R9 forced clear", int'(phase_o), 0);
    check(phase_chg_o, "R6 pulse on clear", int'(phase_chg_o), 1);
    @(negedge clk_i);
    check(!phase_chg_o, "R6 pulse one cycle", int'(phase_chg_o), 0);
    smp(4000, 0, 0, "R9 held at zero");
    wr(4, 686);
    check(!cfg_err_o, "R8 error cleared", int'(cfg_err_o), 0);
    wr(1, 700);
    check(cfg_err_o, "R8 overlap phases", int'(cfg_err_o), 1);
    wr(1, 574);
    check(!cfg_err_o, "R8 overlap fixed", int'(cfg_err_o), 0);
    wr(0, 7);
    check(cfg_err_o, "R8 count too large", int'(cfg_err_o), 1);
    wr(0, 2);
    check(!cfg_err_o, "R8 count fixed", int'(cfg_err_o), 0);
    wr(13, 4095);
    check(!cfg_err_o, "R11 out of range write", int'(cfg_err_o), 0);
    smp(574, 1, 1, "R11 entry1 unchanged");

    wr(7, 2000); wr(8, 1700);
    wr(9, 2600); wr(10, 2300);
    wr(11, 3200); wr(12, 2900);
    wr(0, 6);
    check(!cfg_err_o, "R11 six phase config", int'(cfg_err_o), 0);
    smp(4000, 2, 1, "R2 custom to 2");
    smp(4000, 3, 1, "R2 custom to 3");
    smp(4000, 4, 1, "R2 custom to 4");
    smp(4000, 5, 1, "R2 custom to 5");
    smp(4000, 6, 1, "R2 custom to 6");
    smp(4000, 6, 0, "R7 custom cap");
    smp(2899, 5, 1, "R3 below exit6");
    smp(2300, 5, 0, "R4 equal exit5 holds");
    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, "R6 monitor drained", exp_q.size(), 0);
    finish_run();
  end

endmodule